// File: doc/BRIEF.md
# Memory Fill Engine

This block writes a single 64-bit pattern over a contiguous range of memory. A typical use is setting every word of an error-corrected memory to a known value once training has finished. A controller supplies four things: a destination start address, a length in bytes, and two 32-bit halves of the pattern. It then pulses `start`. The engine checks the request and answers with a response code one cycle later. If the request is accepted, the engine raises `active` and streams 64-bit write beats on a valid/ready port, one beat per 8 bytes at rising addresses.

The beats are grouped into bursts. The `cfg_burst_log2` input sets the longest burst to 2^n beats, and `mem_wlast` closes each burst. When the length is not a multiple of 8, the final beat carries a partial byte-enable mask. After the last beat is accepted, `active` falls, `done` pulses for one cycle, and a sticky `irq` bit is set. The `irq` bit stays set until `irq_clr` is asserted.

Some requests are refused without starting: a request made while a fill is running, a length out of range, and a destination address that is not aligned. A length of exactly 2^32 bytes is first reduced to 2^32−1, and only then checked against the limits.

Top module: `memfill_engine`

## Requirements
- R1: A `start` with acceptable parameters gives `rsp_valid`=1 with `rsp_code`=0 (accepted) on the next cycle. In that same cycle `active` is 1 and the first beat is presented at `cfg_dst`.
- R2: Every beat carries `mem_data` = {`cfg_hi`, `cfg_lo`}, latched at the accepted start. Beat k is at address `cfg_dst` + 8·k.
- R3: Every beat except the last has `mem_be`=0xFF. If the final beat has r<8 bytes left, `mem_be` = 2^r − 1 (bit i enables byte address+i). The fill has ceil(size/8) beats.
- R4: With burst limit n, `mem_wlast`=1 on beats whose index mod 2^n equals 2^n−1, and also on the final beat. It is 0 on all other beats.
- R5: While `mem_valid`=1 and `mem_ready`=0, the beat on the next cycle is unchanged: same valid, address, data, byte enables and `mem_wlast`.
- R6: In the cycle after the final beat is accepted, `active`=0, `mem_valid`=0 and `done`=1. `done` is 0 on the following cycle.
- R7: `irq` becomes 1 with `done`. It stays 1 until a cycle with `irq_clr`=1, after which it is 0.
- R8: A `start` while `active`=1 gives `rsp_code`=1 (busy) and has no effect on the running fill.
- R9: A length below MIN_BYTES or above MAX_BYTES gives `rsp_code`=2 (bad parameter), and no fill starts. The same happens when `cfg_dst[2:0]`≠0.
- R10: A length of exactly 2^32 is treated as 2^32−1 before the range check. It is therefore accepted when MAX_BYTES = 2^32−1, and the first beat is a full beat at `cfg_dst`.
- R11: After reset: `active`, `mem_valid`, `done`, `irq` and `rsp_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, one cycle |
| cfg_dst | input | ADDR_W | Destination start address |
| cfg_size | input | ADDR_W+1 | Length in bytes |
| cfg_hi | input | 32 | Upper pattern half |
| cfg_lo | input | 32 | Lower pattern half |
| cfg_burst_log2 | input | LIM_W | Log2 of the longest burst |
| irq_clr | input | 1 | Clears the sticky irq |
| rsp_valid | output | 1 | Response to a start is valid |
| rsp_code | output | 2 | 0 accepted, 1 busy, 2 bad parameter |
| active | output | 1 | Fill in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Sticky completion flag |
| mem_valid | output | 1 | Write beat valid |
| mem_ready | input | 1 | Memory accepts beat |
| mem_addr | output | ADDR_W | Beat address |
| mem_data | output | 64 | Beat data |
| mem_be | output | 8 | Byte enables |
| mem_wlast | output | 1 | Last beat of a burst |

## Verification
The bench runs lengths that end on a partial beat. A design that computes the tail mask from the wrong bytes, or emits one beat too many or too few, shows up there as a wrong `mem_be` or a beat count that does not match. It stalls `mem_ready` in the middle of bursts and checks that the beat stays frozen, so a sequencer that advances without a handshake is caught. It issues a second start during a stalled fill; a design that loads the new parameters would move `mem_addr` and change the following beats. It also uses the 2^32 length, which a design without the reduction would reject as too large. Finally, it uses bursts that are shorter at the end of the fill, which catch a design that places `mem_wlast` by a free-running count.

// File: rtl/memfill_pkg.sv
package memfill_pkg;

    localparam int BEAT_BYTES = 8;
    localparam int DATA_W     = 64;
    localparam int BE_W       = 8;

    typedef enum logic [1:0] {
        RSP_OK   = 2'd0,
        RSP_BUSY = 2'd1,
        RSP_BAD  = 2'd2
    } rsp_e;

    typedef struct packed {
        logic [31:0] hi;
        logic [31:0] lo;
    } pattern_t;

    // Byte-enable mask for a beat with n bytes remaining (n >= 8 -> full).
    function automatic logic [BE_W-1:0] tail_mask(input logic [3:0] n);
        logic [8:0] m;
        if (n >= 4'd8) begin
            return {BE_W{1'b1}};
        end
        m = (9'd1 << n) - 9'd1;
        return m[BE_W-1:0];
    endfunction

endpackage

// File: rtl/memfill_req_check.sv
module memfill_req_check #(
    parameter int              ADDR_W    = 32,
    parameter longint unsigned MIN_BYTES = 64'd8,
    parameter longint unsigned MAX_BYTES = 64'hFFFF_FFFF,
    localparam int             SIZE_W    = ADDR_W + 1
) (
    input  logic [2:0]        dst_low,
    input  logic [SIZE_W-1:0] size_in,
    output logic [SIZE_W-1:0] size_eff,
    output logic              params_ok
);
    localparam logic [SIZE_W-1:0] FULL_SPAN = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [SIZE_W-1:0] LO_LIM    = SIZE_W'(MIN_BYTES);
    localparam logic [SIZE_W-1:0] HI_LIM    = SIZE_W'(MAX_BYTES);

    always_comb begin
        size_eff  = (size_in == FULL_SPAN) ? (FULL_SPAN - SIZE_W'(1)) : size_in;
        params_ok = (size_eff >= LO_LIM) && (size_eff <= HI_LIM) && (dst_low == 3'd0);
    end

endmodule

// File: rtl/memfill_beat_seq.sv
module memfill_beat_seq
    import memfill_pkg::*;
#(
    parameter  int ADDR_W = 32,
    parameter  int LIM_W  = 3,
    localparam int SIZE_W = ADDR_W + 1,
    localparam int CNT_W  = (1 << LIM_W) - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] dst,
    input  logic [SIZE_W-1:0] size,
    input  logic [LIM_W-1:0]  lim,
    input  logic              fire,
    output logic [ADDR_W-1:0] addr,
    output logic [BE_W-1:0]   be,
    output logic              wlast,
    output logic              final_beat
);
    logic [SIZE_W-1:0] rem_q;
    logic [CNT_W-1:0]  bcnt_q;
    logic [LIM_W-1:0]  lim_q;
    logic [CNT_W:0]    burst_span;
    logic [CNT_W-1:0]  burst_top;

    always_comb begin
        burst_span = (CNT_W + 1)'(1) << lim_q;
        burst_top  = CNT_W'(burst_span - (CNT_W + 1)'(1));
        final_beat = (rem_q <= SIZE_W'(BEAT_BYTES));
        be         = final_beat ? tail_mask(rem_q[3:0]) : {BE_W{1'b1}};
        wlast      = final_beat || (bcnt_q == burst_top);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr   <= '0;
            rem_q  <= '0;
            bcnt_q <= '0;
            lim_q  <= '0;
        end else if (load) begin
            addr   <= dst;
            rem_q  <= size;
            bcnt_q <= '0;
            lim_q  <= lim;
        end else if (fire) begin
            addr   <= addr + ADDR_W'(BEAT_BYTES);
            rem_q  <= final_beat ? '0 : rem_q - SIZE_W'(BEAT_BYTES);
            bcnt_q <= wlast ? '0 : bcnt_q + CNT_W'(1);
        end
    end

    // R4
    burst_len_chk: assert property (@(posedge clk) disable iff (rst)
        fire |-> (bcnt_q <= burst_top));

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !final_beat) |=> (addr == $past(addr) + ADDR_W'(BEAT_BYTES)));

endmodule

// File: rtl/memfill_engine.sv
module memfill_engine
    import memfill_pkg::*;
#(
    parameter  int              ADDR_W    = 32,
    parameter  int              LIM_W     = 3,
    parameter  longint unsigned MIN_BYTES = 64'd8,
    parameter  longint unsigned MAX_BYTES = 64'hFFFF_FFFF,
    localparam int              SIZE_W    = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_dst,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [31:0]       cfg_hi,
    input  logic [31:0]       cfg_lo,
    input  logic [LIM_W-1:0]  cfg_burst_log2,
    input  logic              irq_clr,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic              active,
    output logic              done,
    output logic              irq,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [BE_W-1:0]   mem_be,
    output logic              mem_wlast
);
    logic [SIZE_W-1:0] size_eff;
    logic              params_ok;
    logic              load;
    logic              fire;
    logic              final_beat;
    pattern_t          pat_q;
    rsp_e              rsp_q;

    memfill_req_check #(
        .ADDR_W   (ADDR_W),
        .MIN_BYTES(MIN_BYTES),
        .MAX_BYTES(MAX_BYTES)
    ) u_check (
        .dst_low  (cfg_dst[2:0]),
        .size_in  (cfg_size),
        .size_eff (size_eff),
        .params_ok(params_ok)
    );

    assign load      = start && !active && params_ok;
    assign mem_valid = active;
    assign fire      = active && mem_ready;
    assign mem_data  = pat_q;
    assign rsp_code  = rsp_q;

    memfill_beat_seq #(
        .ADDR_W(ADDR_W),
        .LIM_W (LIM_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .dst       (cfg_dst),
        .size      (size_eff),
        .lim       (cfg_burst_log2),
        .fire      (fire),
        .addr      (mem_addr),
        .be        (mem_be),
        .wlast     (mem_wlast),
        .final_beat(final_beat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_q     <= RSP_OK;
            done      <= 1'b0;
            irq       <= 1'b0;
            pat_q     <= '0;
        end else begin
            rsp_valid <= start;
            done      <= 1'b0;
            if (start) begin
                if (active) begin
                    rsp_q <= RSP_BUSY;
                end else if (!params_ok) begin
                    rsp_q <= RSP_BAD;
                end else begin
                    rsp_q  <= RSP_OK;
                    active <= 1'b1;
                    pat_q  <= '{hi: cfg_hi, lo: cfg_lo};
                end
            end
            if (fire && final_beat) begin
                active <= 1'b0;
                done   <= 1'b1;
            end
            if (fire && final_beat) begin
                irq <= 1'b1;
            end else if (irq_clr) begin
                irq <= 1'b0;
            end
        end
    end

    // R5
    hold_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)
                                       && $stable(mem_be) && $stable(mem_wlast)));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!active && !mem_valid));

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    // R8
    busy_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (start && active) |=> (rsp_valid && rsp_code == RSP_BUSY));

    // R9
    bad_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == RSP_BAD) |-> !mem_valid);

    // R3
    be_shape_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_be != '0 && $onehot0({1'b0, mem_be} + 9'd1)));

endmodule

// File: tb/tb_memfill_engine.sv
module tb_memfill_engine;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int SIZE_W = ADDR_W + 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] cfg_dst = '0;
    logic [SIZE_W-1:0] cfg_size = '0;
    logic [31:0]       cfg_hi = '0;
    logic [31:0]       cfg_lo = '0;
    logic [2:0]        cfg_burst_log2 = '0;
    logic              irq_clr = 1'b0;
    logic              rsp_valid;
    logic [1:0]        rsp_code;
    logic              active, done, irq;
    logic              mem_valid;
    logic              mem_ready = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [63:0]       mem_data;
    logic [7:0]        mem_be;
    logic              mem_wlast;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memfill_engine dut (
        .clk(clk), .rst(rst), .start(start), .cfg_dst(cfg_dst), .cfg_size(cfg_size),
        .cfg_hi(cfg_hi), .cfg_lo(cfg_lo), .cfg_burst_log2(cfg_burst_log2),
        .irq_clr(irq_clr), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .active(active), .done(done), .irq(irq), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_be(mem_be), .mem_wlast(mem_wlast)
    );

    task automatic check(input bit ok, input string tag, input longint unsigned act,
                         input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic req(input logic [31:0] dst, input logic [32:0] size, input logic [2:0] lim,
                       input logic [31:0] hi, input logic [31:0] lo, input logic [1:0] exp_code,
                       input string tag);
        @(negedge clk);
        cfg_dst = dst; cfg_size = size; cfg_burst_log2 = lim;
        cfg_hi = hi; cfg_lo = lo; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(rsp_valid === 1'b1, tag, rsp_valid, 1);
        check(rsp_code === exp_code, tag, rsp_code, exp_code);
    endtask

    // mode 0: ready always; 1: alternating; 2: one cycle in four
    function automatic logic ready_pat(input int mode, input int cyc);
        if (mode == 0) return 1'b1;
        if (mode == 1) return cyc[0];
        return (cyc % 4) == 3;
    endfunction

    task automatic drain(input logic [31:0] dst, input logic [32:0] size, input logic [2:0] lim,
                         input logic [31:0] hi, input logic [31:0] lo, input int mode);
        longint unsigned nbeats = (longint'(size) + 7) / 8;
        longint unsigned i = 0;
        int cyc = 0;
        int burst = 1 << lim;
        bit held = 0;
        logic [31:0] s_addr;
        logic [7:0]  s_be;
        logic        s_last;
        logic [63:0] s_data;
        while (i < nbeats && cyc < 5000) begin
            if (held) begin
                check(mem_valid === 1'b1 && mem_addr === s_addr && mem_be === s_be &&
                      mem_wlast === s_last && mem_data === s_data,
                      "R5 beat held while stalled", mem_addr, s_addr);
                held = 0;
            end
            mem_ready = ready_pat(mode, cyc);
            if (mem_valid && mem_ready) begin
                longint unsigned rem = longint'(size) - 8 * i;
                logic [7:0] ebe = (rem >= 8) ? 8'hFF : 8'((9'd1 << rem) - 9'd1);
                logic elast = ((i % burst) == burst - 1) || (i == nbeats - 1);
                check(mem_addr === dst + 32'(8 * i), "R2 beat address", mem_addr, dst + 32'(8 * i));
                check(mem_data === {hi, lo}, "R2 beat pattern", mem_data, {hi, lo});
                check(mem_be === ebe, "R3 byte enables", mem_be, ebe);
                check(mem_wlast === elast, "R4 burst last", mem_wlast, elast);
                i++;
            end else if (mem_valid) begin
                s_addr = mem_addr; s_be = mem_be; s_last = mem_wlast; s_data = mem_data;
                held = 1;
            end
            cyc++;
            @(negedge clk);
        end
        mem_ready = 1'b0;
        check(i == nbeats, "R3 beat count", i, nbeats);
        check(active === 1'b0 && mem_valid === 1'b0, "R6 idle after last beat", active, 0);
        check(done === 1'b1, "R6 done pulse", done, 1);
        check(irq === 1'b1, "R7 irq set", irq, 1);
        @(negedge clk);
        check(done === 1'b0, "R6 done one cycle", done, 0);
        check(irq === 1'b1, "R7 irq sticky", irq, 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(active === 0 && mem_valid === 0 && done === 0 && irq === 0 && rsp_valid === 0,
              "R11 reset state", {active, mem_valid, done, irq, rsp_valid}, 0);
    endtask

    task automatic t_full_fill();
        req(32'h0000_1000, 33'd64, 3'd2, 32'hDEAD_BEEF, 32'h0BAD_F00D, 2'd0, "R1 accept");
        check(active === 1'b1 && mem_valid === 1'b1, "R1 active after start", active, 1);
        check(mem_addr === 32'h1000, "R1 first beat address", mem_addr, 32'h1000);
        drain(32'h0000_1000, 33'd64, 3'd2, 32'hDEAD_BEEF, 32'h0BAD_F00D, 0);
    endtask

    task automatic t_irq_clear();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        check(irq === 1'b0, "R7 irq cleared", irq, 0);
    endtask

    task automatic t_partial_stall();
        req(32'h0000_2008, 33'd20, 3'd1, 32'h1234_5678, 32'h9ABC_DEF0, 2'd0, "R1 accept partial");
        drain(32'h0000_2008, 33'd20, 3'd1, 32'h1234_5678, 32'h9ABC_DEF0, 1);
        req(32'h0000_3000, 33'd83, 3'd3, 32'hA5A5_0001, 32'h5A5A_0002, 2'd0, "R1 accept long");
        drain(32'h0000_3000, 33'd83, 3'd3, 32'hA5A5_0001, 32'h5A5A_0002, 2);
        req(32'h0000_4000, 33'd13, 3'd0, 32'h0000_0001, 32'h0000_0002, 2'd0, "R1 accept single");
        drain(32'h0000_4000, 33'd13, 3'd0, 32'h0000_0001, 32'h0000_0002, 0);
    endtask

    task automatic t_busy();
        mem_ready = 1'b0;
        req(32'h0000_5000, 33'd32, 3'd1, 32'hCAFE_0000, 32'h0000_CAFE, 2'd0, "R8 first accept");
        repeat (2) @(negedge clk);
        req(32'h0000_9000, 33'd200, 3'd3, 32'h1111_1111, 32'h2222_2222, 2'd1, "R8 busy code");
        check(mem_addr === 32'h5000, "R8 busy start ignored", mem_addr, 32'h5000);
        check(mem_data === {32'hCAFE_0000, 32'h0000_CAFE}, "R8 pattern kept", mem_data,
              {32'hCAFE_0000, 32'h0000_CAFE});
        drain(32'h0000_5000, 33'd32, 3'd1, 32'hCAFE_0000, 32'h0000_CAFE, 1);
    endtask

    task automatic t_bad();
        req(32'h0000_6000, 33'd4, 3'd1, 32'h1, 32'h2, 2'd2, "R9 size below min");
        check(active === 0 && mem_valid === 0, "R9 no fill small", active, 0);
        req(32'h0000_6000, 33'd0, 3'd1, 32'h1, 32'h2, 2'd2, "R9 size zero");
        check(active === 0 && mem_valid === 0, "R9 no fill zero", active, 0);
        req(32'h0000_6004, 33'd64, 3'd1, 32'h1, 32'h2, 2'd2, "R9 misaligned dst");
        check(active === 0 && mem_valid === 0, "R9 no fill misaligned", active, 0);
        req(32'h0000_0000, 33'h1_0000_0008, 3'd1, 32'h1, 32'h2, 2'd2, "R9 size above max");
        check(active === 0 && mem_valid === 0, "R9 no fill large", active, 0);
    endtask

    task automatic t_clamp();
        req(32'h0000_0000, 33'h1_0000_0000, 3'd7, 32'hFEED_FACE, 32'hC0DE_C0DE, 2'd0, "R10 4G accepted");
        check(active === 1'b1 && mem_addr === 32'h0, "R10 fill running", mem_addr, 0);
        check(mem_be === 8'hFF, "R10 first beat full", mem_be, 8'hFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_full_fill();
        t_irq_clear();
        t_partial_stall();
        t_busy();
        t_bad();
        t_clamp();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule